// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from a translation table in memory, in one or two levels. A start pulse captures the virtual address, the table base and a per-walk tiny-page enable. The walker then issues one 32-bit descriptor read at a time over a request/grant/response memory port.

The first-level entry has three valid forms:
- A section, which finishes the walk at once.
- A coarse table, which leads to a second read.
- A fine table, which also leads to a second read.

The second-level entry can describe a large, small or tiny page. Each form splits the virtual address differently and keeps its permission field in a different place.

At the end of a walk the block raises a single-cycle done pulse and presents the following results:
- the physical address
- a page type code
- the cacheable/bufferable pair
- the 4-bit domain
- the access permission field
- a fault flag

The results stay on the outputs until the following walk completes. The block keeps no cache of translations and does not check permissions.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk is at address {base[31:14], VA[31:20], 2'b00}.
- R2: A first-level entry with bits [1:0] = 10 is a section. The walk ends after one read with:
  - PA = {desc[31:20], VA[19:0]}
  - type code 0
  - cb = desc[3:2]
  - ap = desc[11:10], zero-extended to 8 bits
- R3: A first-level entry with bits [1:0] = 01 is a coarse table. The second read is at {desc[31:10], VA[19:12], 2'b00}.
- R4: A first-level entry with bits [1:0] = 11 is a fine table when tiny support is enabled. The second read is at {desc[31:12], VA[19:10], 2'b00}.
- R5: Two first-level cases end the walk with the fault flag set after exactly one read:
  - bits [1:0] = 00
  - bits [1:0] = 11 while the tiny enable input was low at start
- R6: A second-level entry with bits [1:0] = 01 is a large page:
  - PA = {desc[31:16], VA[15:0]}
  - type code 1
  - ap = desc[11:4]
- R7: A second-level entry with bits [1:0] = 10 is a small page:
  - PA = {desc[31:12], VA[11:0]}
  - type code 2
  - ap = desc[11:4]
- R8: A second-level entry with bits [1:0] = 11 is a tiny page:
  - PA = {desc[31:10], VA[9:0]}
  - type code 3
  - ap = {6'b0, desc[5:4]}
- R9: A second-level entry with bits [1:0] = 00 ends the walk with the fault flag set after two reads.
- R10: The domain output is first-level bits [8:5] for every non-faulting walk. For page walks, cb is second-level bits [3:2].
- R11: The memory request and its address stay stable until the grant is seen. The next request is issued only after the response.
- R12: A start pulse is ignored while a walk is in progress.
- R13: Each walk ends with exactly one done pulse, and the outputs hold their values between walks. When the fault flag is set, PA, type, cb, domain and ap are all zero.
- R14: After reset the following outputs are all low or zero: done, fault, request and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| va_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | Translation table base; bits [13:0] ignored |
| tiny_en_i | input | 1 | Allow fine first-level entries |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a translation fault |
| pa_o | output | 32 | Physical address |
| ptype_o | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| cb_o | output | 2 | Cacheable/bufferable bits |
| domain_o | output | 4 | Domain number |
| ap_o | output | 8 | Access permission field |

## Verification
The bound assertions check, on every cycle:
- the first-level address generated right after an accepted start
- that requests and their addresses stay stable until they are granted
- that done is a single-cycle pulse and that results hold between walks
- that faults carry a zero address
- that tiny pages never set the upper permission bits

Only the bench scenarios can show the following:
- that each descriptor form picks the right address split and permission field
- that second-level addresses are correct
- that sections and first-level faults make a single read
- that a start pulse in the middle of a walk leaves the result untouched

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   localparam int DOM_W = 4;
   localparam int AP_W  = 8;
   localparam int CB_W  = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT
   } walk_st_t;

   typedef enum logic [1:0] {
      PG_SECTION = 2'd0,
      PG_LARGE   = 2'd1,
      PG_SMALL   = 2'd2,
      PG_TINY    = 2'd3
   } page_t;

   // first-level entry kinds after the tiny-support filter
   typedef enum logic [1:0] {
      K1_FAULT,
      K1_SECTION,
      K1_COARSE,
      K1_FINE
   } l1_kind_t;

   typedef struct packed {
      logic             fault;
      logic [31:0]      pa;
      page_t            ptype;
      logic [CB_W-1:0]  cb;
      logic [DOM_W-1:0] domain;
      logic [AP_W-1:0]  ap;
   } walk_res_t;

   function automatic walk_res_t fault_result();
      walk_res_t r;
      r        = '0;
      r.fault  = 1'b1;
      r.ptype  = PG_SECTION;
      return r;
   endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] ttb_i,
   input  logic [ADDR_W-1:0] va_i,
   input  logic [ADDR_W-1:0] l1_desc_i,
   input  logic              fine_i,
   output logic [ADDR_W-1:0] l1_addr_o,
   output logic [ADDR_W-1:0] l2_addr_o
);
   localparam int BASE_LSB   = 14;
   localparam int SECT_LSB   = 20;
   localparam int COARSE_LSB = 10;
   localparam int FINE_LSB   = 12;

   logic unused_bits;
   assign unused_bits = ^{ttb_i[BASE_LSB-1:0], va_i[9:0], l1_desc_i[9:0]};

   assign l1_addr_o = {ttb_i[ADDR_W-1:BASE_LSB], va_i[ADDR_W-1:SECT_LSB], 2'b00};

   always_comb begin
      if (fine_i) begin
         l2_addr_o = {l1_desc_i[ADDR_W-1:FINE_LSB], va_i[SECT_LSB-1:10], 2'b00};
      end else begin
         l2_addr_o = {l1_desc_i[ADDR_W-1:COARSE_LSB], va_i[SECT_LSB-1:12], 2'b00};
      end
   end

endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
   import ptw_pkg::*;
#(
   parameter bit TINY_SUPPORT = 1'b1
) (
   input  logic [31:0]      desc_i,
   input  logic [19:0]      va_lo_i,
   input  logic             tiny_en_i,
   output l1_kind_t         kind_o,
   output walk_res_t        res_o
);
   logic fine_ok;
   logic unused_bits;
   assign unused_bits = ^{desc_i[19:12], desc_i[9], desc_i[4]};

   generate
      if (TINY_SUPPORT) begin : g_fine_opt
         assign fine_ok = tiny_en_i;
      end else begin : g_fine_never
         logic unused_en;
         assign unused_en = tiny_en_i;
         assign fine_ok   = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (desc_i[1:0])
         2'b01:   kind_o = K1_COARSE;
         2'b10:   kind_o = K1_SECTION;
         2'b11:   kind_o = fine_ok ? K1_FINE : K1_FAULT;
         default: kind_o = K1_FAULT;
      endcase
   end

   always_comb begin
      if (kind_o == K1_FAULT) begin
         res_o = fault_result();
      end else begin
         res_o        = '0;
         res_o.fault  = 1'b0;
         res_o.pa     = {desc_i[31:20], va_lo_i};
         res_o.ptype  = PG_SECTION;
         res_o.cb     = desc_i[3:2];
         res_o.domain = desc_i[8:5];
         res_o.ap     = {{(AP_W-2){1'b0}}, desc_i[11:10]};
      end
   end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
   import ptw_pkg::*;
(
   input  logic [31:0]      desc_i,
   input  logic [15:0]      va_lo_i,
   input  logic [DOM_W-1:0] domain_i,
   output walk_res_t        res_o
);
   always_comb begin
      res_o        = '0;
      res_o.cb     = desc_i[3:2];
      res_o.domain = domain_i;
      unique case (desc_i[1:0])
         2'b01: begin
            res_o.ptype = PG_LARGE;
            res_o.pa    = {desc_i[31:16], va_lo_i};
            res_o.ap    = desc_i[11:4];
         end
         2'b10: begin
            res_o.ptype = PG_SMALL;
            res_o.pa    = {desc_i[31:12], va_lo_i[11:0]};
            res_o.ap    = desc_i[11:4];
         end
         2'b11: begin
            res_o.ptype = PG_TINY;
            res_o.pa    = {desc_i[31:10], va_lo_i[9:0]};
            res_o.ap    = {{(AP_W-2){1'b0}}, desc_i[5:4]};
         end
         default: res_o = fault_result();
      endcase
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter bit TINY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] va_i,
   input  logic [ADDR_W-1:0] ttb_i,
   input  logic              tiny_en_i,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [ADDR_W-1:0] mem_rdata_i,
   output logic              done_o,
   output logic              fault_o,
   output logic [ADDR_W-1:0] pa_o,
   output logic [1:0]        ptype_o,
   output logic [CB_W-1:0]   cb_o,
   output logic [DOM_W-1:0]  domain_o,
   output logic [AP_W-1:0]   ap_o
);
   generate
      if (ADDR_W != 32) begin : g_bad_width
         $error("pt_walker: descriptor formats need ADDR_W == 32");
      end
   endgenerate

   walk_st_t          st_q;
   logic [ADDR_W-1:0] va_q, ttb_q, l1_q;
   logic              tiny_q;
   walk_res_t         res_q;
   logic              done_q;

   l1_kind_t          l1_kind;
   walk_res_t         l1_res, l2_res;
   logic [ADDR_W-1:0] l1_addr, l2_addr;
   logic              l1_fine;

   assign l1_fine = (l1_q[1:0] == 2'b11);

   ptw_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .ttb_i     (ttb_q),
      .va_i      (va_q),
      .l1_desc_i (l1_q),
      .fine_i    (l1_fine),
      .l1_addr_o (l1_addr),
      .l2_addr_o (l2_addr)
   );

   ptw_l1_decode #(.TINY_SUPPORT(TINY_SUPPORT)) u_l1 (
      .desc_i    (mem_rdata_i),
      .va_lo_i   (va_q[19:0]),
      .tiny_en_i (tiny_q),
      .kind_o    (l1_kind),
      .res_o     (l1_res)
   );

   ptw_l2_decode u_l2 (
      .desc_i    (mem_rdata_i),
      .va_lo_i   (va_q[15:0]),
      .domain_i  (l1_q[8:5]),
      .res_o     (l2_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         va_q   <= '0;
         ttb_q  <= '0;
         l1_q   <= '0;
         tiny_q <= 1'b0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  va_q   <= va_i;
                  ttb_q  <= ttb_i;
                  tiny_q <= tiny_en_i;
                  st_q   <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_gnt_i) st_q <= ST_L1_WAIT;
            ST_L1_WAIT: begin
               if (mem_rvalid_i) begin
                  if (l1_kind == K1_FAULT || l1_kind == K1_SECTION) begin
                     res_q  <= l1_res;
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     l1_q <= mem_rdata_i;
                     st_q <= ST_L2_REQ;
                  end
               end
            end
            ST_L2_REQ: if (mem_gnt_i) st_q <= ST_L2_WAIT;
            ST_L2_WAIT: begin
               if (mem_rvalid_i) begin
                  res_q  <= l2_res;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign mem_req_o  = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign mem_addr_o = (st_q == ST_L2_REQ) ? l2_addr : l1_addr;
   assign done_o     = done_q;
   assign fault_o    = res_q.fault;
   assign pa_o       = res_q.pa;
   assign ptype_o    = res_q.ptype;
   assign cb_o       = res_q.cb;
   assign domain_o   = res_q.domain;
   assign ap_o       = res_q.ap;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic [31:0] va_i,
   input logic [31:0] ttb_i,
   input logic        busy_o,
   input logic        mem_req_o,
   input logic [31:0] mem_addr_o,
   input logic        mem_gnt_i,
   input logic        done_o,
   input logic        fault_o,
   input logic [31:0] pa_o,
   input logic [1:0]  ptype_o,
   input logic [7:0]  ap_o
);
   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_i && !busy_o) |-> (mem_req_o &&
         mem_addr_o == {$past(ttb_i[31:14]), $past(va_i[31:20]), 2'b00})); // R1

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11

   AST_REQ_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_gnt_i) |=> !mem_req_o); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R13

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(pa_o) && $stable(fault_o) && $stable(ptype_o) && $stable(ap_o))); // R13

   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o) |-> (pa_o == 32'h0 && ap_o == 8'h0)); // R13

   AST_TINY_AP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o && ptype_o == 2'd3) |-> (ap_o[7:2] == 6'h0)); // R8

endmodule

bind pt_walker ptw_checker u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

   typedef struct packed {
      logic [31:0] va;
      logic [31:0] ttb;
      logic        tiny;
      logic [31:0] l1a;
      logic [31:0] l1d;
      logic [31:0] l2a;
      logic [31:0] l2d;
      logic [1:0]  nrd;
      logic        flt;
      logic [31:0] pa;
      logic [1:0]  pt;
      logic [1:0]  cb;
      logic [3:0]  dom;
      logic [7:0]  ap;
      logic [1:0]  gap;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      // section
      '{32'h12345678, 32'h00080000, 1'b0, 32'h0008048C, 32'hABC00CAE, 32'h0, 32'h0,
        2'd1, 1'b0, 32'hABC45678, 2'd0, 2'd3, 4'd5, 8'h03, 2'd0},
      // coarse -> small
      '{32'h00403ABC, 32'h00100000, 1'b0, 32'h00100010, 32'h00200521, 32'h0020040C, 32'h87654A56,
        2'd2, 1'b0, 32'h87654ABC, 2'd2, 2'd1, 4'd9, 8'hA5, 2'd1},
      // coarse -> large
      '{32'h00F12345, 32'h00004000, 1'b0, 32'h0000403C, 32'h003009E1, 32'h00300848, 32'hCAFE03C9,
        2'd2, 1'b0, 32'hCAFE2345, 2'd1, 2'd2, 4'd15, 8'h3C, 2'd2},
      // fine -> tiny
      '{32'h056789AB, 32'h0000C000, 1'b1, 32'h0000C158, 32'h00401063, 32'h00401788, 32'h13579C2F,
        2'd2, 1'b0, 32'h13579DAB, 2'd3, 2'd3, 4'd3, 8'h02, 2'd0},
      // fine -> small
      '{32'h7FF00FFF, 32'h00004000, 1'b1, 32'h00005FFC, 32'h00502023, 32'h0050200C, 32'h2468AFF2,
        2'd2, 1'b0, 32'h2468AFFF, 2'd2, 2'd0, 4'd1, 8'hFF, 2'd1},
      // fine with tiny disabled -> fault
      '{32'h056789AB, 32'h0000C000, 1'b0, 32'h0000C158, 32'h00401063, 32'h0, 32'h0,
        2'd1, 1'b1, 32'h0, 2'd0, 2'd0, 4'd0, 8'h00, 2'd0},
      // first-level fault
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFC, 32'hFFFFFFFC, 32'h0, 32'h0,
        2'd1, 1'b1, 32'h0, 2'd0, 2'd0, 4'd0, 8'h00, 2'd2},
      // second-level fault
      '{32'h00403ABC, 32'h00100000, 1'b1, 32'h00100010, 32'h00200521, 32'h0020040C, 32'hFFFFFFFC,
        2'd2, 1'b1, 32'h0, 2'd0, 2'd0, 4'd0, 8'h00, 2'd0},
      // section, low base bits ignored
      '{32'h80000001, 32'h00007FFF, 1'b0, 32'h00006000, 32'h00000002, 32'h0, 32'h0,
        2'd1, 1'b0, 32'h00000001, 2'd0, 2'd0, 4'd0, 8'h00, 2'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] va_i = '0, ttb_i = '0;
   logic        tiny_en_i = 1'b0;
   logic        busy_o, mem_req_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
   logic [31:0] mem_addr_o, mem_rdata_i = '0;
   logic        done_o, fault_o;
   logic [31:0] pa_o;
   logic [1:0]  ptype_o, cb_o;
   logic [3:0]  domain_o;
   logic [7:0]  ap_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .ttb_i(ttb_i),
      .tiny_en_i(tiny_en_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i(mem_rdata_i), .done_o(done_o), .fault_o(fault_o), .pa_o(pa_o),
      .ptype_o(ptype_o), .cb_o(cb_o), .domain_o(domain_o), .ap_o(ap_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input vec_t v);
      if (v.flt) return (v.nrd == 2'd1) ? "R5" : "R9";
      case (v.pt)
         2'd0:    return "R2";
         2'd1:    return "R6";
         2'd2:    return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic run_walk(input vec_t v, input bit poke);
      int reads;
      int idle;
      logic [31:0] seen;
      string t;
      t = tag_of(v);
      va_i = v.va; ttb_i = v.ttb; tiny_en_i = v.tiny; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      reads = 0;
      idle  = 0;
      while (!done_o && idle < 50) begin
         if (mem_req_o) begin
            seen = mem_addr_o;
            for (int g = 0; g < int'(v.gap); g++) begin
               if (poke && g == 0) begin
                  va_i = 32'hFFFFFFFF; ttb_i = 32'h0; tiny_en_i = ~v.tiny; start_i = 1'b1;
               end
               @(negedge clk);
               start_i = 1'b0;
               check("R11", "request held", {31'h0, mem_req_o}, 32'h1);
               check("R11", "address held", mem_addr_o, seen);
            end
            if (reads == 0) check("R1", "first-level address", mem_addr_o, v.l1a);
            else check(v.l1d[1:0] == 2'b11 ? "R4" : "R3", "second-level address",
                       mem_addr_o, v.l2a);
            mem_gnt_i = 1'b1;
            @(negedge clk);
            mem_gnt_i = 1'b0;
            check("R11", "request dropped while waiting", {31'h0, mem_req_o}, 32'h0);
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = (reads == 0) ? v.l1d : v.l2d;
            reads++;
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            mem_rdata_i  = 32'h0;
         end else begin
            @(negedge clk);
            idle++;
         end
      end
      check("R13", "done seen", {31'h0, done_o}, 32'h1);
      check(t, "read count", reads, {30'h0, v.nrd});
      check(t, "fault", {31'h0, fault_o}, {31'h0, v.flt});
      check(t, "pa", pa_o, v.pa);
      check(v.flt ? "R13" : t, "type", {30'h0, ptype_o}, {30'h0, v.pt});
      check(v.flt ? "R13" : "R10", "cb", {30'h0, cb_o}, {30'h0, v.cb});
      check(v.flt ? "R13" : "R10", "domain", {28'h0, domain_o}, {28'h0, v.dom});
      check(v.flt ? "R13" : t, "ap", {24'h0, ap_o}, {24'h0, v.ap});
      @(negedge clk);
      check("R13", "done is one cycle", {31'h0, done_o}, 32'h0);
      check("R13", "pa holds", pa_o, v.pa);
      check("R12", "idle after walk", {31'h0, busy_o}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R14 reset state, sampled while reset is still asserted
      check("R14", "done in reset", {31'h0, done_o}, 32'h0);
      check("R14", "req in reset", {31'h0, mem_req_o}, 32'h0);
      check("R14", "busy in reset", {31'h0, busy_o}, 32'h0);
      check("R14", "fault in reset", {31'h0, fault_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R14", "idle after reset", {31'h0, busy_o}, 32'h0);

      for (int i = 0; i < NV; i++) run_walk(VECS[i], 1'b0);

      // R12: start pulse during a walk must not alter the walk in progress
      begin
         vec_t pv;
         pv = VECS[1];
         pv.gap = 2'd2;
         run_walk(pv, 1'b1);
      end
      begin
         vec_t pv;
         pv = VECS[3];
         pv.gap = 2'd1;
         run_walk(pv, 1'b1);
      end

      // R13: outputs keep the last result while nothing is started
      repeat (5) @(negedge clk);
      check("R13", "pa holds while idle", pa_o, 32'h13579DAB);
      check("R13", "ptype holds while idle", {30'h0, ptype_o}, 32'd3);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule